// File: doc/BRIEF.md
# Synchronized-Enable Event Counter

This block keeps a wide up-counter in one clock domain and lets logic in a second, unrelated clock domain switch that counter on and off. The on/off request is a single level held in a register owned by the writing side. It is updated through a simple write-enable/data pair and cleared by that side's own reset.

The level never reaches the counter directly. Each writer-clock cycle, a launch flop copies the control register, so only a plain flop output drives the boundary. On the counting side, a chain of two or more flops resynchronizes it. The first flop of the chain feeds only the next one. The counter looks only at the last stage and adds one on every counting-clock cycle in which that stage is high. When it reaches its all-ones value it rolls over to zero.

Top module: `xsync_enable_counter`

## Requirements
- R1: After the writer reset, the control register and the launch flop are 0. After the counting-side reset, the resync flops and `count` are 0. With no write after reset, `count` stays 0.
- R2: On a rising `wr_clk` edge with `wr_en` high, the control register takes `wr_bit`. With `wr_en` low it keeps its value, whatever `wr_bit` does.
- R3: On each rising `cnt_clk` edge, `count` increases by exactly one if the last resync stage is 1. If that stage is 0, `count` is unchanged.
- R4: The launch flop copies the control register on every `wr_clk` edge. The resync chain (default two stages) moves that value one stage per `cnt_clk` edge. The first change of `count` therefore falls on the third `cnt_clk` edge strictly after the launch flop takes a new 1.
- R5: `count` wraps from its all-ones value (2^CNT_W - 1) to 0 and continues counting.
- R6: Asserting `wr_rst` clears the control bit. Once the cleared level has crossed, `count` holds its value, and the counting-side reset is not needed for this.
- R7: Asserting `cnt_rst` sets `count` to 0 while it is held, without disturbing the writer side. After release, counting resumes from 0 if the control bit is still 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Writer-side clock |
| wr_rst | input | 1 | Writer-side synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control bit |
| wr_bit | input | 1 | Value written into the control bit |
| cnt_clk | input | 1 | Counting-side clock |
| cnt_rst | input | 1 | Counting-side synchronous active-high reset |
| count | output | CNT_W | Registered counter value |

## Verification
The hardest condition to reach from the ports is an exact cycle count between a write and the first increment, because the two clocks are unrelated. The stimulus places the writer's rising edges on half-nanosecond offsets, so they never coincide with counting-clock edges. It then measures counting-clock edges from the launch-flop capture under both a fast and a slow writer clock. Rollover is reached by running an 8-bit configuration past 255 with the bit held high. A reference model clocked by the same two clocks is compared against `count` on every counting cycle.

// File: rtl/xsync_pkg.sv
package xsync_pkg;
  localparam int unsigned DefCntW   = 32;
  localparam int unsigned DefStages = 2;
endpackage

// File: rtl/xsync_src_reg.sv
// Writer-side control register plus the launch flop that drives the crossing.
module xsync_src_reg (
  input  logic wr_clk,
  input  logic wr_rst,
  input  logic wr_en,
  input  logic wr_bit,
  output logic launch_q
);
  logic ctrl_q;

  always_ff @(posedge wr_clk) begin
    if (wr_rst)     ctrl_q <= 1'b0;
    else if (wr_en) ctrl_q <= wr_bit;
  end

  // Launch flop: copies the control register every cycle; nothing between it and the far side.
  always_ff @(posedge wr_clk) begin
    if (wr_rst) launch_q <= 1'b0;
    else        launch_q <= ctrl_q;
  end

  p_load_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_en |=> (ctrl_q == $past(wr_bit)));
  p_hold_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !wr_en |=> $stable(ctrl_q));
  p_launch_lag_r4: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (launch_q != $past(launch_q)) |-> (launch_q == $past(ctrl_q)));
endmodule

// File: rtl/xsync_bit_sync.sv
// Counting-side resync chain. Stage 0 feeds only stage 1; only the last stage leaves.
module xsync_bit_sync #(
  parameter int unsigned STAGES = xsync_pkg::DefStages
) (
  input  logic cnt_clk,
  input  logic cnt_rst,
  input  logic async_in,
  output logic sync_out
);
  localparam int unsigned LastIdx = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge cnt_clk) begin
    if (cnt_rst) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[LastIdx];

  p_chain_order_r4: assert property (@(posedge cnt_clk) disable iff (cnt_rst)
    (sync_out != $past(sync_out)) |-> (sync_out == $past(chain_q[LastIdx-1])));
endmodule

// File: rtl/xsync_counter.sv
// Level-enabled wrapping counter.
module xsync_counter #(
  parameter int unsigned CNT_W = xsync_pkg::DefCntW
) (
  input  logic             cnt_clk,
  input  logic             cnt_rst,
  input  logic             inc_en,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] AllOnes = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] One     = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge cnt_clk) begin
    if (cnt_rst)     count <= '0;
    else if (inc_en) count <= count + One;
  end

  p_step_r3: assert property (@(posedge cnt_clk) disable iff (cnt_rst)
    (inc_en && count != AllOnes) |=> (count > $past(count)));
  p_idle_r3: assert property (@(posedge cnt_clk) disable iff (cnt_rst)
    !inc_en |=> $stable(count));
  p_wrap_r5: assert property (@(posedge cnt_clk) disable iff (cnt_rst)
    (inc_en && count == AllOnes) |=> (count == '0));
  p_reset_zero_r7: assert property (@(posedge cnt_clk)
    cnt_rst |=> (count == '0));
endmodule

// File: rtl/xsync_enable_counter.sv
module xsync_enable_counter #(
  parameter int unsigned CNT_W       = xsync_pkg::DefCntW,
  parameter int unsigned SYNC_STAGES = xsync_pkg::DefStages
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             cnt_clk,
  input  logic             cnt_rst,
  output logic [CNT_W-1:0] count
);
  logic launch_q;
  logic enable_sync;

  xsync_src_reg u_src (
    .wr_clk   (wr_clk),
    .wr_rst   (wr_rst),
    .wr_en    (wr_en),
    .wr_bit   (wr_bit),
    .launch_q (launch_q)
  );

  xsync_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .cnt_clk  (cnt_clk),
    .cnt_rst  (cnt_rst),
    .async_in (launch_q),
    .sync_out (enable_sync)
  );

  xsync_counter #(.CNT_W(CNT_W)) u_cnt (
    .cnt_clk (cnt_clk),
    .cnt_rst (cnt_rst),
    .inc_en  (enable_sync),
    .count   (count)
  );
endmodule

// File: tb/sim_xsync_enable_counter.sv
`timescale 1ns/1ps
module sim_xsync_enable_counter;
  localparam int W = 8;
  localparam int Mask = (1 << W) - 1;

  logic wr_clk = 1'b0, cnt_clk = 1'b0;
  logic wr_rst = 1'b1, cnt_rst = 1'b1;
  logic wr_en = 1'b0, wr_bit = 1'b0;
  logic [W-1:0] count;
  realtime wr_half = 3.5;

  int n_chk = 0, n_bad = 0;
  string phase = "R1";
  bit done = 1'b0, wrap_seen = 1'b0;
  logic [W-1:0] prev_count = '0;

  // Reference model built from the requirements
  logic m_ctrl = 1'b0, m_ff0 = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0;
  logic [W-1:0] m_cnt = '0;

  xsync_enable_counter #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_bit(wr_bit),
    .cnt_clk(cnt_clk), .cnt_rst(cnt_rst), .count(count)
  );

  always #5 cnt_clk = ~cnt_clk;
  always #(wr_half) wr_clk = ~wr_clk;

  always @(posedge wr_clk) begin
    if (wr_rst) begin m_ctrl <= 1'b0; m_ff0 <= 1'b0; end
    else begin
      if (wr_en) m_ctrl <= wr_bit;
      m_ff0 <= m_ctrl;
    end
  end

  always @(posedge cnt_clk) begin
    if (cnt_rst) begin m_s1 <= 1'b0; m_s2 <= 1'b0; m_cnt <= '0; end
    else begin
      m_s1 <= m_ff0; m_s2 <= m_s1;
      if (m_s2) m_cnt <= m_cnt + 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge cnt_clk) begin
    if (!done) begin
      check(count === m_cnt, phase, int'(count), int'(m_cnt));
      if (!cnt_rst && prev_count == W'(Mask) && count == '0) wrap_seen = 1'b1;
      prev_count = count;
    end
  end

  task automatic wait_cnt(input int n);
    for (int i = 0; i < n; i++) @(negedge cnt_clk);
  endtask

  task automatic write_bit(input logic v);
    @(negedge wr_clk); wr_en = 1'b1; wr_bit = v;
    @(negedge wr_clk); wr_en = 1'b0; wr_bit = 1'b0;
  endtask

  // Writes 1 and measures counting edges from the launch capture to the first change.
  task automatic latency_probe(input string req);
    int n;
    logic [W-1:0] start;
    n = 0;
    @(negedge wr_clk); wr_en = 1'b1; wr_bit = 1'b1;
    @(posedge wr_clk);
    @(negedge wr_clk); wr_en = 1'b0; wr_bit = 1'b0;
    @(posedge wr_clk);
    start = count;
    for (int i = 0; i < 10; i++) begin
      @(posedge cnt_clk); n++;
      @(negedge cnt_clk);
      if (count != start) break;
    end
    check(n == 3, req, n, 3);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] c0;
    wait_cnt(5);
    check(count == '0, "R1", int'(count), 0);
    @(negedge wr_clk); wr_rst = 1'b0;
    @(negedge cnt_clk); cnt_rst = 1'b0;
    wait_cnt(20);
    check(count == '0, "R1", int'(count), 0);

    // R2: data toggling with strobe low has no effect
    phase = "R2";
    @(negedge wr_clk); wr_bit = 1'b1;
    for (int i = 0; i < 10; i++) @(negedge wr_clk);
    wr_bit = 1'b0;
    wait_cnt(10);
    check(count == '0, "R2", int'(count), 0);

    // R4 with fast writer clock
    phase = "R4";
    latency_probe("R4 fast writer");

    // R3 counting and holding
    phase = "R3";
    wait_cnt(10);
    c0 = count;
    wait_cnt(17);
    check(int'(count) == ((int'(c0) + 17) & Mask), "R3 step", int'(count), (int'(c0) + 17) & Mask);
    write_bit(1'b0);
    wait_cnt(10);
    c0 = count;
    wait_cnt(20);
    check(count == c0, "R3 hold", int'(count), int'(c0));

    // R4 with slow writer clock (switch at a rising edge keeps edges off the counting grid)
    @(posedge wr_clk); wr_half = 17.5;
    phase = "R4";
    wait_cnt(10);
    latency_probe("R4 slow writer");

    // R5 rollover
    phase = "R5";
    wait_cnt(300);
    check(wrap_seen, "R5 wrap", int'(wrap_seen), 1);

    // R6 writer reset stops counting
    phase = "R6";
    @(negedge wr_clk); wr_rst = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge wr_clk);
    wr_rst = 1'b0;
    wait_cnt(10);
    c0 = count;
    wait_cnt(20);
    check(count == c0, "R6", int'(count), int'(c0));

    // R7 counting-side reset
    phase = "R7";
    write_bit(1'b1);
    wait_cnt(30);
    @(negedge cnt_clk); cnt_rst = 1'b1;
    wait_cnt(3);
    check(count == '0, "R7 held", int'(count), 0);
    cnt_rst = 1'b0;
    wait_cnt(10);
    check(count == m_cnt && count != '0 && count < 8'd12, "R7 resume", int'(count), int'(m_cnt));
    finish_run();
  end
endmodule